// File: doc/BRIEF.md
# Rotating-Pointer Round-Robin Arbiter

This block picks one winner among a vector of request lines and spreads service fairly by rotating the starting point of its search. A register holds the index that won last. Each cycle the block looks for the first asserted request strictly above that index, moving toward higher indices and wrapping from the top index back to zero. The remembered index itself is therefore the last candidate examined. The search is combinational, so the winning index and the value the pointer will take appear in the same cycle as the requests.

The search has no serial scan. A threshold mask keeps only the requests above the pointer, and a balanced trailing-zero tree finds the lowest survivor. A second tree of the same shape finds the lowest request overall, which is the wrapped answer. The logic depth therefore grows with log2 of the number of inputs. When the number of inputs is not a power of two, the trees are padded with zero leaves, and the pointer never holds a value outside the legal index range.

Top module: `rot_ptr_arbiter`

## Requirements
- R1: After the synchronous active-low reset is released, the stored pointer is 0. With no requests, `next_ptr` reads 0.
- R2: When no request is asserted, `grant_idx` is 0 and `next_ptr` equals the stored pointer.
- R3: The search starts at pointer+1 and moves upward. The first asserted request found wins: a request at pointer+1 (modulo NUM_REQ) always wins, and a request below the pointer never beats one above it.
- R4: When no request lies above the pointer, the search wraps, and the lowest asserted index wins. The pointer's own index is considered last, so a lone request there is granted.
- R5: When any request is asserted, `next_ptr` equals `grant_idx`.
- R6: At each rising clock edge, the stored pointer takes the value `next_ptr` held just before the edge. It changes only when that value differs from the current pointer.
- R7: `grant_idx` and `next_ptr` are always below NUM_REQ, including when NUM_REQ is not a power of two.
- R8: When any request is asserted, the bit of `req` selected by `grant_idx` is 1.
- R9: Indices are binary. Bit i of `req` is granted as the value i on `grant_idx`, which is $clog2(NUM_REQ) bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NUM_REQ | Request lines, bit i is requester i |
| grant_idx | output | $clog2(NUM_REQ) | Binary index of the winning request, 0 when idle |
| next_ptr | output | $clog2(NUM_REQ) | Value the pointer takes at the next edge |

## Verification
A grant and a wraparound can happen in the same cycle. When no request lies above the pointer but some request lies at or below it, the block must drop the masked search result, take the unmasked one, and move the pointer backward at the next edge. The bench sets up this case by first parking the pointer high with a single request and then presenting only low requests, including one at the pointer's own index. A serial wrap-scan model, run for both an 8-input and a 7-input instance, judges the grant and the next pointer in every cycle.

// File: rtl/rra_pkg.sv
package rra_pkg;

    localparam int RRA_MIN_REQ = 2;

    function automatic int rra_idx_width(input int n);
        return (n < RRA_MIN_REQ) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rra_above_mask.sv
module rra_above_mask #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = 3
) (
    input  logic [IDX_W-1:0]   ptr_i,
    output logic [NUM_REQ-1:0] above_o
);

    // one constant-threshold comparator per lane: depth is one compare
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_lane
        localparam logic [IDX_W-1:0] LANE_POS = IDX_W'(i);
        assign above_o[i] = (LANE_POS > ptr_i);
    end

endmodule

// File: rtl/rra_tz_count.sv
module rra_tz_count #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_REQ-1:0] vec_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   pos_o
);

    localparam int PAD   = 1 << IDX_W;
    localparam int NODES = 2 * PAD - 1;

    logic [PAD-1:0]   vec_pad;
    logic [NODES-1:0] node_v;
    logic [IDX_W-1:0] node_p [NODES];

    if (PAD > NUM_REQ) begin : g_pad
        assign vec_pad = {{(PAD - NUM_REQ){1'b0}}, vec_i};
    end else begin : g_nopad
        assign vec_pad = vec_i;
    end

    // leaves: heap slots PAD-1 .. 2*PAD-2, leaf j is bit j
    for (genvar j = 0; j < PAD; j++) begin : g_leaf
        assign node_v[PAD-1+j] = vec_pad[j];
        assign node_p[PAD-1+j] = '0;
    end

    // internal nodes: lower half wins, upper half adds its level bit
    for (genvar d = 0; d < IDX_W; d++) begin : g_level
        localparam int LVL_BIT = IDX_W - 1 - d;
        for (genvar j = 0; j < (1 << d); j++) begin : g_node
            localparam int K  = (1 << d) - 1 + j;
            localparam int LO = 2 * K + 1;
            localparam int HI = 2 * K + 2;
            assign node_v[K] = node_v[LO] | node_v[HI];
            assign node_p[K] = node_v[LO] ? node_p[LO]
                                          : (node_p[HI] | (IDX_W'(1) << LVL_BIT));
        end
    end

    assign found_o = node_v[0];
    assign pos_o   = node_p[0];

endmodule

// File: rtl/rot_ptr_arbiter.sv
module rot_ptr_arbiter
    import rra_pkg::*;
#(
    parameter int NUM_REQ = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_REQ-1:0]                   req,
    output logic [rra_idx_width(NUM_REQ)-1:0]    grant_idx,
    output logic [rra_idx_width(NUM_REQ)-1:0]    next_ptr
);

    localparam int IDX_W = rra_idx_width(NUM_REQ);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [NUM_REQ-1:0] above_mask;
    logic [NUM_REQ-1:0] req_above;
    logic               hi_found, any_found;
    logic [IDX_W-1:0]   hi_pos, any_pos;
    logic [IDX_W-1:0]   grant_d;
    logic [IDX_W-1:0]   next_ptr_d;

    rra_above_mask #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_mask (
        .ptr_i   (state_q.ptr),
        .above_o (above_mask)
    );

    assign req_above = req & above_mask;

    rra_tz_count #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_tz_above (
        .vec_i   (req_above),
        .found_o (hi_found),
        .pos_o   (hi_pos)
    );

    rra_tz_count #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_tz_all (
        .vec_i   (req),
        .found_o (any_found),
        .pos_o   (any_pos)
    );

    always_comb begin
        grant_d    = '0;
        next_ptr_d = state_q.ptr;
        if (hi_found) begin
            grant_d    = hi_pos;
            next_ptr_d = hi_pos;
        end else if (any_found) begin
            grant_d    = any_pos;
            next_ptr_d = any_pos;
        end
        state_d = state_q;
        if (next_ptr_d != state_q.ptr) begin
            state_d.ptr = next_ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant_idx = grant_d;
    assign next_ptr  = next_ptr_d;

endmodule

// File: rtl/rra_checker.sv
module rra_checker
    import rra_pkg::*;
#(
    parameter int NUM_REQ = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_REQ-1:0]                req,
    input logic [rra_idx_width(NUM_REQ)-1:0] grant_idx,
    input logic [rra_idx_width(NUM_REQ)-1:0] next_ptr
);

    localparam int IDX_W = rra_idx_width(NUM_REQ);

    logic             warm;
    logic [IDX_W-1:0] seen_ptr;
    logic [IDX_W-1:0] succ_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm     <= 1'b0;
            seen_ptr <= '0;
        end else begin
            warm     <= 1'b1;
            seen_ptr <= next_ptr;
        end
    end

    assign succ_idx = (seen_ptr == IDX_W'(NUM_REQ - 1)) ? '0 : seen_ptr + 1'b1;

    AST_IDLE_GRANT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (grant_idx == '0)); // R2

    AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && req == '0) |-> (next_ptr == seen_ptr)); // R6

    AST_NEXT_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (next_ptr == grant_idx)); // R5

    AST_GRANT_IS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> req[grant_idx]); // R8

    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(grant_idx) < NUM_REQ) && (32'(next_ptr) < NUM_REQ)); // R7

    AST_SUCCESSOR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && req[succ_idx]) |-> (grant_idx == succ_idx)); // R3

    AST_SELF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && req == (NUM_REQ'(1) << seen_ptr)) |-> (grant_idx == seen_ptr)); // R4

endmodule

bind rot_ptr_arbiter rra_checker #(.NUM_REQ(NUM_REQ)) u_rra_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .grant_idx (grant_idx),
    .next_ptr  (next_ptr)
);

// File: tb/test_rot_ptr_arbiter.sv
`timescale 1ns/1ps
module test_rot_ptr_arbiter;

    localparam real CLK_HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_a = '0;
    logic [6:0] req_b = '0;
    logic [2:0] grant_a, next_a, grant_b, next_b;

    int n_checks = 0;
    int n_errors = 0;
    int mptr_a   = 0;
    int mptr_b   = 0;

    always #(CLK_HALF) clk = ~clk;

    rot_ptr_arbiter #(.NUM_REQ(8)) i_rot_ptr_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req_a),
        .grant_idx(grant_a), .next_ptr(next_a)
    );

    rot_ptr_arbiter #(.NUM_REQ(7)) i_rot_ptr_arbiter_odd (
        .clk(clk), .rst_n(rst_n), .req(req_b),
        .grant_idx(grant_b), .next_ptr(next_b)
    );

    // serial wrap-scan model: first set bit from ptr+1 upward, ptr itself last
    function automatic int ref_pick(input int n, input int ptr, input logic [7:0] r);
        for (int k = 1; k <= n; k++) begin
            int idx = (ptr + k) % n;
            if (r[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic chk(input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] ra, input logic [6:0] rb, input string tag);
        int pa, pb, ga, na, gb, nb;
        @(negedge clk);
        req_a = ra;
        req_b = rb;
        #1;
        pa = ref_pick(8, mptr_a, ra);
        pb = ref_pick(7, mptr_b, {1'b0, rb});
        ga = (pa < 0) ? 0 : pa;
        na = (pa < 0) ? mptr_a : pa;
        gb = (pb < 0) ? 0 : pb;
        nb = (pb < 0) ? mptr_b : pb;
        chk(int'(grant_a), ga, {tag, " grant n8"});
        chk(int'(next_a),  na, {tag, " next n8"});
        chk(int'(grant_b), gb, {tag, " grant n7"});
        chk(int'(next_b),  nb, {tag, " next n7"});
        chk(int'(grant_b < 3'd7 && next_b < 3'd7), 1, "R7 range n7");
        mptr_a = na;
        mptr_b = nb;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req_a = '0;
        req_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        mptr_a = 0;
        mptr_b = 0;
        step('0, '0, "R1 reset idle");
        step('0, '0, "R2 idle");
    endtask

    task automatic t_single_sweep();
        for (int i = 0; i < 8; i++) begin
            step(8'(1 << i), 7'(1 << (i % 7)), "R9 single index");
            step('0, '0, "R6 pointer loaded");
        end
    endtask

    task automatic t_full_rotation();
        for (int i = 0; i < 18; i++) begin
            step('1, '1, "R3 all requests rotate");
        end
    endtask

    task automatic t_direction();
        step(8'h08, 7'h08, "R5 park at 3");
        step(8'h14, 7'h14, "R3 above beats below");
        step(8'h14, 7'h14, "R4 wrap to lower");
    endtask

    task automatic t_wrap_self();
        step(8'h20, 7'h20, "R5 park at 5");
        step(8'h24, 7'h24, "R4 wrap below pointer");
        step(8'h04, 7'h04, "R4 self last");
        step(8'h04, 7'h04, "R4 self repeat");
        step(8'h80, 7'h40, "R5 park top");
        step(8'h01, 7'h01, "R4 wrap top to zero");
        step('0, '0, "R2 idle after wrap");
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            logic [7:0] ra;
            logic [6:0] rb;
            ra = 8'($urandom);
            rb = 7'($urandom);
            if ((i % 5) == 0) ra = '0;
            if ((i % 7) == 0) rb = '0;
            if ((i % 3) == 1) ra = ra & 8'($urandom);
            step(ra, rb, "R8 random stream");
        end
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        n_errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single_sweep();
        t_full_rotation();
        t_direction();
        t_wrap_self();
        t_random();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule